// File: doc/BRIEF.md
# Adaptive Memory Command Throttler

This block sits on the command path between a memory controller's scheduler and the DRAM. Each cycle it either passes a command through or holds it back. Time is cut into fixed throttle intervals. The first T cycles of every interval are a stall window, and the rest of the interval lets traffic flow. While it passes commands, the block counts those it issues: reads, writes, and commands flagged as bank conflicts.

At the last cycle of every epoch, which is much longer than an interval, the block captures the three counts together with a power target and five model coefficients. A small state machine then evaluates a signed fixed-point linear model of these values and clamps the result to a legal stall length. The new length becomes current at the next interval boundary. Software fits the coefficients elsewhere and only loads them here. The estimator walks four named states. EST_IDLE waits. The EPOCH_DONE transition leads to EST_ACCUM, which adds one model term per cycle. TERMS_DONE leads to EST_CLAMP, which limits the result. CLAMP_DONE leads to EST_PEND, which holds the result. INTERVAL_WRAP loads the held result and returns to EST_IDLE. An epoch end seen in any state restarts EST_ACCUM.

Top module: `mem_cmd_throttle`

## Requirements
- R1: During reset and right after it, `cur_delay` is 0 and all three captured counts are 0, so no cycle is stalled until the first new value is loaded.
- R2: When a cycle is not stalled, `dn_valid` equals `up_valid`, `up_ready` equals `dn_ready`, and `dn_cmd` always equals `up_cmd`.
- R3: Cycles are numbered from 0 at reset release. The position inside the interval is the cycle number modulo INTERVAL_LEN. With `enable` high, a cycle is stalled when its position is below `cur_delay`. A stalled cycle drives `dn_valid` and `up_ready` to 0.
- R4: The new stall length is floor((c0 + c1*P + c2*R + c3*W + c4*B) / 256). The coefficients `coef0`..`coef4` are signed Q8.8 values. P, R, W and B are unsigned integers: the power target and the read, write and conflict counts. A negative result gives 0, and a result above INTERVAL_LEN gives INTERVAL_LEN.
- R5: The accumulator is a 32-bit signed register. It adds the terms in the order c0, P, R, W, B, and after each addition it saturates to the range from -2^31 to 2^31-1.
- R6: A command is issued in a cycle where `dn_valid` and `dn_ready` are both 1. An issued command adds to the write count when `up_is_write` is 1 and to the read count otherwise. It adds to the conflict count when `up_bank_conflict` is 1. An epoch's last cycle is one where the cycle number modulo EPOCH_LEN is EPOCH_LEN-1. The counts, including that last cycle's command, appear on `cap_*` from the next cycle, and the live counts restart at 0.
- R7: Each count stops at 2^CNT_W-1 and does not wrap.
- R8: Let k be the last cycle of an epoch. The value computed from that epoch becomes `cur_delay` in the first cycle j that is a multiple of INTERVAL_LEN with j >= k+8. `cur_delay` never changes inside an interval.
- R9: With `enable` low, no cycle is stalled. Counting and estimation carry on unchanged.
- R10: The power target and the coefficients used by the model are the values present on the last cycle of the epoch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High applies the stall window, low bypasses it |
| power_target | input | PWR_W | Unsigned power target, model input P |
| coef0 | input | COEF_W | Signed Q8.8 constant term |
| coef1 | input | COEF_W | Signed Q8.8 weight of the power target |
| coef2 | input | COEF_W | Signed Q8.8 weight of the read count |
| coef3 | input | COEF_W | Signed Q8.8 weight of the write count |
| coef4 | input | COEF_W | Signed Q8.8 weight of the conflict count |
| up_valid | input | 1 | Scheduler offers a command |
| up_ready | output | 1 | Command accepted from the scheduler |
| up_cmd | input | CMD_W | Command payload |
| up_is_write | input | 1 | Offered command is a write |
| up_bank_conflict | input | 1 | Offered command hits a bank conflict |
| dn_valid | output | 1 | Command presented to the DRAM path |
| dn_ready | input | 1 | DRAM path can take a command |
| dn_cmd | output | CMD_W | Command payload towards DRAM |
| cur_delay | output | TW | Stall length in force this interval |
| cap_reads | output | CNT_W | Read count of the last finished epoch |
| cap_writes | output | CNT_W | Write count of the last finished epoch |
| cap_conflicts | output | CNT_W | Conflict count of the last finished epoch |

## Verification
The bench builds the block with INTERVAL_LEN 20, EPOCH_LEN 100 and CNT_W 6, so eleven epochs and more than fifty interval boundaries fit in about 1,100 cycles. The 6-bit counts saturate within a single epoch of full-rate traffic with the bypass on. At that size, coefficient sets drive the model result below zero, above the interval length, and past the 32-bit accumulator limit. Because epoch ends line up with interval ends, each new value must wait out a whole interval before it loads.

// File: rtl/thr_pkg.sv
package thr_pkg;

    typedef enum logic [1:0] {
        EST_IDLE,
        EST_ACCUM,
        EST_CLAMP,
        EST_PEND
    } est_state_t;

    localparam int NUM_TERMS = 5;
    localparam int NUM_CNT   = 3;
    localparam int CNT_RD    = 0;
    localparam int CNT_WR    = 1;
    localparam int CNT_CF    = 2;

endpackage

// File: rtl/thr_timebase.sv
module thr_timebase #(
    parameter int INTERVAL_LEN = 10000,
    parameter int EPOCH_LEN    = 1000000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    output logic [$clog2(INTERVAL_LEN)-1:0] icnt,
    output logic                            interval_last,
    output logic                            epoch_last
);
    localparam int IW = $clog2(INTERVAL_LEN);
    localparam int EW = $clog2(EPOCH_LEN);

    logic [EW-1:0] ecnt;

    assign interval_last = (icnt == IW'(INTERVAL_LEN - 1));
    assign epoch_last    = (ecnt == EW'(EPOCH_LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            icnt <= '0;
            ecnt <= '0;
        end else begin
            icnt <= interval_last ? '0 : icnt + IW'(1);
            ecnt <= epoch_last    ? '0 : ecnt + EW'(1);
        end
    end
endmodule

// File: rtl/thr_sat_cnt.sv
module thr_sat_cnt #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         flush,
    output logic [W-1:0] cap
);
    logic [W-1:0] cnt;
    logic [W-1:0] cnt_nxt;

    // stop at all-ones instead of wrapping
    always_comb begin
        cnt_nxt = cnt;
        if (inc && (cnt != {W{1'b1}}))
            cnt_nxt = cnt + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            cap <= '0;
        end else if (flush) begin
            cap <= cnt_nxt;
            cnt <= '0;
        end else begin
            cnt <= cnt_nxt;
        end
    end
endmodule

// File: rtl/thr_gate.sv
module thr_gate #(
    parameter int IW = 14,
    parameter int TW = 14
) (
    input  logic          enable,
    input  logic [IW-1:0] icnt,
    input  logic [TW-1:0] cur_delay,
    input  logic          up_valid,
    input  logic          dn_ready,
    output logic          dn_valid,
    output logic          up_ready
);
    logic stall;

    assign stall    = enable && (TW'(icnt) < cur_delay);
    assign dn_valid = up_valid && !stall;
    assign up_ready = dn_ready && !stall;
endmodule

// File: rtl/thr_estimator.sv
module thr_estimator
    import thr_pkg::*;
#(
    parameter int INTERVAL_LEN = 10000,
    parameter int CNT_W        = 20,
    parameter int PWR_W        = 16,
    parameter int COEF_W       = 16,
    parameter int FRAC_W       = 8,
    parameter int ACC_W        = 32,
    parameter int TW           = 14
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              epoch_last,
    input  logic                              interval_last,
    input  logic [PWR_W-1:0]                  power_target,
    input  logic [NUM_TERMS-1:0][COEF_W-1:0]  coef_in,
    input  logic [CNT_W-1:0]                  cnt_rd,
    input  logic [CNT_W-1:0]                  cnt_wr,
    input  logic [CNT_W-1:0]                  cnt_cf,
    output logic [TW-1:0]                     cur_delay
);
    localparam int OPW      = ((CNT_W > PWR_W) ? CNT_W : PWR_W) + 1;
    localparam int PROD_W   = COEF_W + OPW;
    localparam int SUM_W    = ((PROD_W > ACC_W) ? PROD_W : ACC_W) + 1;
    localparam int IDX_W    = $clog2(NUM_TERMS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TERMS - 1);
    localparam logic signed [SUM_W-1:0] SUM_MAX =
        {{(SUM_W - ACC_W + 1){1'b0}}, {(ACC_W - 1){1'b1}}};
    localparam logic signed [SUM_W-1:0] SUM_MIN =
        {{(SUM_W - ACC_W + 1){1'b1}}, {(ACC_W - 1){1'b0}}};
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W - 1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W - 1){1'b0}}};
    localparam logic signed [ACC_W-1:0] LIM_S   = ACC_W'(INTERVAL_LEN);

    est_state_t state, state_n;

    logic [IDX_W-1:0]                 idx;
    logic signed [ACC_W-1:0]          acc;
    logic signed [ACC_W-1:0]          acc_nxt;
    logic [PWR_W-1:0]                 pwr_q;
    logic [NUM_TERMS-1:0][COEF_W-1:0] coef_q;
    logic [TW-1:0]                    pend;
    logic [TW-1:0]                    clamped;

    // ---- term selection: one coefficient and one operand per cycle ----
    logic [COEF_W-1:0] cf_u;
    logic [OPW-1:0]    op_u;

    always_comb begin
        case (idx)
            IDX_W'(0): begin cf_u = coef_q[0]; op_u = OPW'(1);      end
            IDX_W'(1): begin cf_u = coef_q[1]; op_u = OPW'(pwr_q);  end
            IDX_W'(2): begin cf_u = coef_q[2]; op_u = OPW'(cnt_rd); end
            IDX_W'(3): begin cf_u = coef_q[3]; op_u = OPW'(cnt_wr); end
            IDX_W'(4): begin cf_u = coef_q[4]; op_u = OPW'(cnt_cf); end
            default:   begin cf_u = '0;        op_u = '0;           end
        endcase
    end

    // ---- signed multiply at full width, then saturating add ----
    logic signed [PROD_W-1:0] cf_x, op_x, prod;
    logic signed [SUM_W-1:0]  acc_x, prod_x, sum;

    assign cf_x   = {{OPW{cf_u[COEF_W-1]}}, cf_u};
    assign op_x   = {{COEF_W{1'b0}}, op_u};
    assign prod   = cf_x * op_x;
    assign acc_x  = {{(SUM_W - ACC_W){acc[ACC_W-1]}}, acc};
    assign prod_x = {{(SUM_W - PROD_W){prod[PROD_W-1]}}, prod};
    assign sum    = acc_x + prod_x;

    always_comb begin
        if (sum > SUM_MAX)
            acc_nxt = ACC_MAX;
        else if (sum < SUM_MIN)
            acc_nxt = ACC_MIN;
        else
            acc_nxt = sum[ACC_W-1:0];
    end

    // ---- drop fraction and limit to one interval ----
    logic signed [ACC_W-1:0] whole;

    assign whole = acc >>> FRAC_W;

    always_comb begin
        if (acc[ACC_W-1])
            clamped = '0;
        else if (whole > LIM_S)
            clamped = TW'(INTERVAL_LEN);
        else
            clamped = whole[TW-1:0];
    end

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= EST_IDLE;
        else
            state <= state_n;
    end

    // ---- transitions: EPOCH_DONE, TERMS_DONE, CLAMP_DONE, INTERVAL_WRAP ----
    always_comb begin
        state_n = state;
        unique case (state)
            EST_IDLE:  state_n = EST_IDLE;
            EST_ACCUM: if (idx == LAST_IDX) state_n = EST_CLAMP;
            EST_CLAMP: state_n = EST_PEND;
            EST_PEND:  if (interval_last) state_n = EST_IDLE;
        endcase
        if (epoch_last)
            state_n = EST_ACCUM;
    end

    // ---- outputs and datapath registers ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            acc       <= '0;
            pwr_q     <= '0;
            coef_q    <= '0;
            pend      <= '0;
            cur_delay <= '0;
        end else begin
            if (epoch_last) begin
                idx    <= '0;
                acc    <= '0;
                pwr_q  <= power_target;
                coef_q <= coef_in;
            end else if (state == EST_ACCUM) begin
                idx <= idx + IDX_W'(1);
                acc <= acc_nxt;
            end
            if (state == EST_CLAMP)
                pend <= clamped;
            if ((state == EST_PEND) && interval_last)
                cur_delay <= pend;
        end
    end
endmodule

// File: rtl/mem_cmd_throttle.sv
module mem_cmd_throttle
    import thr_pkg::*;
#(
    parameter int INTERVAL_LEN = 10000,
    parameter int EPOCH_LEN    = 1000000,
    parameter int CNT_W        = 20,
    parameter int PWR_W        = 16,
    parameter int COEF_W       = 16,
    parameter int FRAC_W       = 8,
    parameter int ACC_W        = 32,
    parameter int CMD_W        = 32,
    localparam int TW          = $clog2(INTERVAL_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [PWR_W-1:0]  power_target,
    input  logic [COEF_W-1:0] coef0,
    input  logic [COEF_W-1:0] coef1,
    input  logic [COEF_W-1:0] coef2,
    input  logic [COEF_W-1:0] coef3,
    input  logic [COEF_W-1:0] coef4,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [CMD_W-1:0]  up_cmd,
    input  logic              up_is_write,
    input  logic              up_bank_conflict,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [CMD_W-1:0]  dn_cmd,
    output logic [TW-1:0]     cur_delay,
    output logic [CNT_W-1:0]  cap_reads,
    output logic [CNT_W-1:0]  cap_writes,
    output logic [CNT_W-1:0]  cap_conflicts
);
    localparam int IW = $clog2(INTERVAL_LEN);

    logic [IW-1:0] icnt;
    logic          interval_last;
    logic          epoch_last;
    logic          issue;

    thr_timebase #(
        .INTERVAL_LEN (INTERVAL_LEN),
        .EPOCH_LEN    (EPOCH_LEN)
    ) u_tb (
        .clk           (clk),
        .rst_n         (rst_n),
        .icnt          (icnt),
        .interval_last (interval_last),
        .epoch_last    (epoch_last)
    );

    thr_gate #(
        .IW (IW),
        .TW (TW)
    ) u_gate (
        .enable    (enable),
        .icnt      (icnt),
        .cur_delay (cur_delay),
        .up_valid  (up_valid),
        .dn_ready  (dn_ready),
        .dn_valid  (dn_valid),
        .up_ready  (up_ready)
    );

    assign dn_cmd = up_cmd;
    assign issue  = dn_valid && dn_ready;

    logic [NUM_CNT-1:0]            inc_vec;
    logic [NUM_CNT-1:0][CNT_W-1:0] cap_vec;

    assign inc_vec[CNT_RD] = issue && !up_is_write;
    assign inc_vec[CNT_WR] = issue &&  up_is_write;
    assign inc_vec[CNT_CF] = issue &&  up_bank_conflict;

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        thr_sat_cnt #(
            .W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_vec[gi]),
            .flush (epoch_last),
            .cap   (cap_vec[gi])
        );
    end

    assign cap_reads     = cap_vec[CNT_RD];
    assign cap_writes    = cap_vec[CNT_WR];
    assign cap_conflicts = cap_vec[CNT_CF];

    logic [NUM_TERMS-1:0][COEF_W-1:0] coef_bus;

    assign coef_bus = {coef4, coef3, coef2, coef1, coef0};

    thr_estimator #(
        .INTERVAL_LEN (INTERVAL_LEN),
        .CNT_W        (CNT_W),
        .PWR_W        (PWR_W),
        .COEF_W       (COEF_W),
        .FRAC_W       (FRAC_W),
        .ACC_W        (ACC_W),
        .TW           (TW)
    ) u_est (
        .clk           (clk),
        .rst_n         (rst_n),
        .epoch_last    (epoch_last),
        .interval_last (interval_last),
        .power_target  (power_target),
        .coef_in       (coef_bus),
        .cnt_rd        (cap_vec[CNT_RD]),
        .cnt_wr        (cap_vec[CNT_WR]),
        .cnt_cf        (cap_vec[CNT_CF]),
        .cur_delay     (cur_delay)
    );
endmodule

// File: rtl/mem_cmd_throttle_chk.sv
module mem_cmd_throttle_chk #(
    parameter int INTERVAL_LEN = 10000,
    parameter int CNT_W        = 20
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                enable,
    input logic                                up_valid,
    input logic                                up_ready,
    input logic                                dn_valid,
    input logic                                dn_ready,
    input logic [$clog2(INTERVAL_LEN)-1:0]     icnt,
    input logic [$clog2(INTERVAL_LEN+1)-1:0]   cur_delay,
    input logic                                epoch_last,
    input logic [CNT_W-1:0]                    cap_reads,
    input logic [CNT_W-1:0]                    cap_writes
);
    localparam int TW = $clog2(INTERVAL_LEN + 1);
    localparam logic [TW-1:0] LIM = TW'(INTERVAL_LEN);

    // R2: nothing reaches DRAM that the scheduler did not offer
    a_r2_valid_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> up_valid);

    // R2: the scheduler is never told ready when DRAM is not
    a_r2_ready_needs_sink: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready |-> dn_ready);

    // R3: a nonzero window always covers the first cycle of an interval
    a_r3_stall_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (icnt == '0) && (cur_delay != '0)) |-> (!up_ready && !dn_valid));

    // R4: stall length never exceeds one interval
    a_r4_delay_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cur_delay <= LIM);

    // R8: the window length only moves at an interval start
    a_r8_no_mid_interval_change: assert property (@(posedge clk) disable iff (!rst_n)
        (icnt != '0) |-> $stable(cur_delay));

    // R6: captured counts move only right after an epoch's last cycle
    a_r6_caps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(epoch_last) |-> ($stable(cap_reads) && $stable(cap_writes)));

    // R9: bypass passes handshakes straight through
    a_r9_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> ((up_ready == dn_ready) && (dn_valid == up_valid)));
endmodule

bind mem_cmd_throttle mem_cmd_throttle_chk #(
    .INTERVAL_LEN (INTERVAL_LEN),
    .CNT_W        (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .up_valid   (up_valid),
    .up_ready   (up_ready),
    .dn_valid   (dn_valid),
    .dn_ready   (dn_ready),
    .icnt       (icnt),
    .cur_delay  (cur_delay),
    .epoch_last (epoch_last),
    .cap_reads  (cap_reads),
    .cap_writes (cap_writes)
);

// File: tb/sim_mem_cmd_throttle.sv
module sim_mem_cmd_throttle;
    localparam int CLK_PERIOD = 10;
    localparam int IL    = 20;
    localparam int EL    = 100;
    localparam int CNTW  = 6;
    localparam int CMDW  = 8;
    localparam int TW    = $clog2(IL + 1);
    localparam int TOTAL = 11 * EL + 40;
    localparam longint MAXC = (64'd1 << CNTW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic [15:0] p_drv = '0;
    logic signed [15:0] c_drv [5];
    logic up_valid = 1'b0, up_is_write = 1'b0, up_bank_conflict = 1'b0, dn_ready = 1'b0;
    logic [CMDW-1:0] up_cmd = '0;
    logic up_ready, dn_valid;
    logic [CMDW-1:0] dn_cmd;
    logic [TW-1:0] cur_delay;
    logic [CNTW-1:0] cap_reads, cap_writes, cap_conflicts;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mem_cmd_throttle #(
        .INTERVAL_LEN (IL),
        .EPOCH_LEN    (EL),
        .CNT_W        (CNTW),
        .CMD_W        (CMDW)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .enable (enable), .power_target (p_drv),
        .coef0 (c_drv[0]), .coef1 (c_drv[1]), .coef2 (c_drv[2]),
        .coef3 (c_drv[3]), .coef4 (c_drv[4]),
        .up_valid (up_valid), .up_ready (up_ready), .up_cmd (up_cmd),
        .up_is_write (up_is_write), .up_bank_conflict (up_bank_conflict),
        .dn_valid (dn_valid), .dn_ready (dn_ready), .dn_cmd (dn_cmd),
        .cur_delay (cur_delay), .cap_reads (cap_reads),
        .cap_writes (cap_writes), .cap_conflicts (cap_conflicts)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic longint sat32(input longint v);
        if (v > 64'sd2147483647)  return 64'sd2147483647;
        if (v < -64'sd2147483648) return -64'sd2147483648;
        return v;
    endfunction

    // R4/R5 reference: Q8.8 terms in fixed order, saturate, floor, clamp
    function automatic longint model_t(input longint c0, input longint c1, input longint c2,
                                       input longint c3, input longint c4, input longint p,
                                       input longint r, input longint w, input longint b);
        longint acc, t;
        acc = 0;
        acc = sat32(acc + c0);
        acc = sat32(acc + c1 * p);
        acc = sat32(acc + c2 * r);
        acc = sat32(acc + c3 * w);
        acc = sat32(acc + c4 * b);
        t = acc >>> 8;
        if (t < 0)  t = 0;
        if (t > IL) t = IL;
        return t;
    endfunction

    // per-cycle stimulus; epoch index picks a scenario
    task automatic set_inputs(input int k);
        int e;
        bit full;
        e = k / EL;
        full = (e == 4);
        if (k % EL == 0) begin
            for (int i = 0; i < 5; i++) c_drv[i] = '0;
            enable = 1'b1;
            case (e)
                0: begin c_drv[0] = 16'sd1280; p_drv = 16'd7; end
                1: begin c_drv[1] = 16'sd16; c_drv[2] = -16'sd64; c_drv[3] = 16'sd32;
                         c_drv[4] = 16'sd128; p_drv = 16'd160; end
                2: c_drv[0] = -16'sd4096;
                3: c_drv[0] = 16'sh7FFF;
                4: begin enable = 1'b0; c_drv[1] = 16'sh7FFF; p_drv = 16'hFFFF;
                         c_drv[2] = 16'sh7FFF; c_drv[4] = -16'sd256; end
                5: c_drv[0] = 16'sd3072;
                6: c_drv[1] = 16'sd64;
                default: begin
                    for (int i = 0; i < 5; i++)
                        c_drv[i] = 16'($signed($urandom_range(1023)) - 512);
                    p_drv = 16'($urandom_range(255));
                end
            endcase
        end
        if (e == 6) p_drv = 16'($urandom_range(79));
        up_valid         = full ? 1'b1 : ($urandom_range(3) != 0);
        dn_ready         = full ? 1'b1 : ($urandom_range(3) != 0);
        up_is_write      = full ? ($urandom_range(7) == 0) : ($urandom_range(2) == 0);
        up_bank_conflict = full ? ($urandom_range(1) == 0) : ($urandom_range(3) == 0);
        up_cmd           = CMDW'($urandom);
    endtask

    initial begin
        longint rd_m, wr_m, cf_m, crd_m, cwr_m, ccf_m;
        longint t_act, t_pend, apply_at;
        int src_e;
        int seed_ret;
        bit stall, issue;
        string tg;
        rd_m = 0; wr_m = 0; cf_m = 0; crd_m = 0; cwr_m = 0; ccf_m = 0;
        t_act = 0; t_pend = 0; apply_at = -1; src_e = 0;
        seed_ret = $urandom(32'd20240611);
        for (int i = 0; i < 5; i++) c_drv[i] = '0;

        repeat (3) @(negedge clk);
        // R1: values held in reset
        chk("R1", "cur_delay in reset", longint'(cur_delay), 0);
        chk("R1", "cap_reads in reset", longint'(cap_reads), 0);
        chk("R1", "cap_conflicts in reset", longint'(cap_conflicts), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        for (int k = 0; k < TOTAL; k++) begin
            @(negedge clk);
            set_inputs(k);
            #1;
            if (k == 0) begin
                chk("R1", "cur_delay after reset", longint'(cur_delay), 0);
                chk("R1", "cap_writes after reset", longint'(cap_writes), 0);
            end
            if (longint'(k) == apply_at) begin
                t_act = t_pend;
                tg = (src_e == 4) ? "R5" : ((src_e == 6) ? "R10" : "R4");
                chk(tg, $sformatf("model result of epoch %0d", src_e),
                    longint'(cur_delay), t_act);
            end
            chk("R8", "cur_delay per cycle", longint'(cur_delay), t_act);

            stall = enable && ((k % IL) < t_act);
            tg = !enable ? "R9" : (stall ? "R3" : "R2");
            chk(tg, "dn_valid", longint'(dn_valid), longint'(up_valid && !stall));
            chk(tg, "up_ready", longint'(up_ready), longint'(dn_ready && !stall));
            chk("R2", "dn_cmd", longint'(dn_cmd), longint'(up_cmd));

            chk((crd_m == MAXC) ? "R7" : "R6", "cap_reads",     longint'(cap_reads),     crd_m);
            chk((cwr_m == MAXC) ? "R7" : "R6", "cap_writes",    longint'(cap_writes),    cwr_m);
            chk((ccf_m == MAXC) ? "R7" : "R6", "cap_conflicts", longint'(cap_conflicts), ccf_m);

            issue = up_valid && dn_ready && !stall;
            if (issue) begin
                if (up_is_write) begin if (wr_m < MAXC) wr_m++; end
                else             begin if (rd_m < MAXC) rd_m++; end
                if (up_bank_conflict && cf_m < MAXC) cf_m++;
            end

            if (k % EL == EL - 1) begin
                crd_m = rd_m; cwr_m = wr_m; ccf_m = cf_m;
                rd_m = 0; wr_m = 0; cf_m = 0;
                t_pend = model_t(longint'(c_drv[0]), longint'(c_drv[1]), longint'(c_drv[2]),
                                 longint'(c_drv[3]), longint'(c_drv[4]), longint'(p_drv),
                                 crd_m, cwr_m, ccf_m);
                apply_at = ((longint'(k) + 8 + IL - 1) / IL) * IL;
                src_e = k / EL;
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule